// File: doc/BRIEF.md
# SMI Generation and Lockdown Controller

This block raises an active-low system management interrupt (`smi_n`) from three event sources: a software trigger port, a free-running periodic timer and any attempt to turn on the flash write-enable bit. Each source has its own enable bit, and one global enable bit gates all three. A latched status word records which sources have fired, and firmware clears each bit by writing 1 to it.

Host software programs the block through a small byte-addressed register window. It can write the source-enable register, a sticky lock bit and a BIOS control register. The BIOS control register holds the flash write-enable bit and a protection bit that limits flash writes to system-management mode. Setting the write-enable bit raises an interrupt, so handler firmware can inspect the change and revert it. The sticky lock freezes the global enable, which stops software from suppressing that interrupt first. The `flash_wr_permit` output tells the flash path whether writes are currently allowed.

Top module: `smi_guard_top`

## Requirements
- R1: After reset, `smi_n` is 1, the status word is 0, `flash_wr_permit` is 0, and the enable (0x30), lock (0x40) and BIOS control (0xDC) registers all read 0.
- R2: While bit 0 (global enable) of the enable register is 0, no source drives `smi_n` low. This holds even when the source's own enable bit is set.
- R3: A write to address 0xB2 is a software trigger. When enable bits 0 and 1 are both set, `smi_n` is low for exactly one cycle, in the cycle that follows the write edge.
- R4: When enable bits 0 and 2 are set, the periodic source drives `smi_n` low once every `TICK_PERIOD` clocks.
- R5: A write to 0xDC that changes bit 0 (flash write-enable) from 0 to 1 is a flash event, and it pulses `smi_n` when enable bits 0 and 3 are set. Writing 1 again while the bit is already 1 raises no event.
- R6: Writing bit 0 of address 0x40 sets the lock, and only reset clears it. While the lock is set, writes to 0x30 leave bit 0 unchanged and still update every other bit.
- R7: Each event sets its status bit whether or not it is enabled: bit 1 for the trigger, bit 2 for the periodic timer and bit 3 for the flash event. The status word reads at 0x34, and writing 1 to a status bit at 0x34 clears it.
- R8: After 0xFFFF_FFFE is written to an unlocked enable register, setting the flash write-enable bit raises no pulse. The bit stays set and `flash_wr_permit` goes high.
- R9: Bit 1 of 0xDC is the SMM-only protection bit. `flash_wr_permit` equals `we & (!bwp | smm_active)`, where `we` is the write-enable bit and `bwp` is that protection bit.
- R10: `reg_rdata` returns the addressed register combinationally: the enable word at 0x30, status at 0x34, the lock in bit 0 at 0x40, and write-enable and protection in bits 0 and 1 at 0xDC. Any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low platform reset |
| reg_wr | input | 1 | Register write strobe, sampled on the rising edge |
| reg_addr | input | 8 | Register / port address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| smm_active | input | 1 | Processor is in system-management mode |
| smi_n | output | 1 | Active-low interrupt pulse |
| smi_status | output | 32 | Latched source status word |
| flash_wr_permit | output | 1 | Flash writes currently allowed |

## Verification
A register write takes effect on the clock edge that samples it. Any pulse and status bit that the write causes appear one cycle after the write is driven, at that same edge. The permit output and read data follow with no further register stage. The driver records the expected low cycle of `smi_n` at the moment it issues each write, and the monitor stamps every low sample at the falling edge and compares the stamp against the queue. A pulse that arrives early, arrives late, lasts too long or was never expected therefore shows up as a mismatch. The periodic source has no fixed phase after reset, so the bench checks it by measuring the spacing between successive pulses.

// File: rtl/smi_guard_pkg.sv
package smi_guard_pkg;

    localparam int REG_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_SRC = 3;

    // register window addresses
    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_LOCK    = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_SWPORT  = 8'hB2;
    localparam logic [ADDR_W-1:0] OFS_BIOSCTL = 8'hDC;

    // enable register fields; source i sits at bit i+1
    localparam int BIT_GLOBAL = 0;
    localparam int SRC_SW     = 0;
    localparam int SRC_TICK   = 1;
    localparam int SRC_FLASH  = 2;

    // BIOS control fields
    localparam int BIT_WE  = 0;
    localparam int BIT_BWP = 1;

    typedef struct packed {
        logic [REG_W-1:0] en;
        logic             lock;
        logic             we;
        logic             bwp;
    } cfg_state_t;

endpackage

// File: rtl/smi_cfg_regs.sv
module smi_cfg_regs
    import smi_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  en_q,
    output logic              lock_q,
    output logic              we_q,
    output logic              bwp_q,
    output logic              sw_evt,
    output logic              flash_evt,
    output logic [REG_W-1:0]  clr_mask
);

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        sw_evt    = 1'b0;
        flash_evt = 1'b0;
        clr_mask  = '0;
        if (wr_en) begin
            case (addr)
                OFS_ENABLE: begin
                    st_d.en = wdata;
                    if (st_q.lock) begin
                        st_d.en[BIT_GLOBAL] = st_q.en[BIT_GLOBAL];
                    end
                end
                OFS_LOCK: begin
                    st_d.lock = st_q.lock | wdata[0];
                end
                OFS_BIOSCTL: begin
                    st_d.we   = wdata[BIT_WE];
                    st_d.bwp  = wdata[BIT_BWP];
                    flash_evt = wdata[BIT_WE] & ~st_q.we;
                end
                OFS_SWPORT: begin
                    sw_evt = 1'b1;
                end
                OFS_STATUS: begin
                    clr_mask = wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_q   = st_q.en;
    assign lock_q = st_q.lock;
    assign we_q   = st_q.we;
    assign bwp_q  = st_q.bwp;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> st_q.lock); // R6

    AST_LOCK_FREEZES_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lock |=> $stable(st_q.en[BIT_GLOBAL])); // R6

    AST_WE_SET_IS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.we && st_d.we) |-> flash_evt); // R5

endmodule

// File: rtl/smi_tick_gen.sv
module smi_tick_gen #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);

    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick = (st_q.cnt == LAST);

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R4

endmodule

// File: rtl/smi_event_core.sv
module smi_event_core #(
    parameter int NSRC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            glb_en,
    input  logic [NSRC-1:0] src_en,
    input  logic [NSRC-1:0] evt,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] status,
    output logic            smi_n
);

    typedef struct packed {
        logic [NSRC-1:0] sts;
        logic            smi_n;
    } core_state_t;

    core_state_t st_d, st_q;

    logic [NSRC-1:0] sts_nx;
    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign sts_nx[g] = (st_q.sts[g] & ~clr[g]) | evt[g];
        assign hit[g]    = evt[g] & src_en[g];
    end

    always_comb begin
        st_d       = st_q;
        st_d.sts   = sts_nx;
        st_d.smi_n = ~(glb_en & (|hit));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sts   <= '0;
            st_q.smi_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status = st_q.sts;
    assign smi_n  = st_q.smi_n;

    AST_NO_GLOBAL_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> smi_n); // R2

    AST_PULSE_HAS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_n |-> (|status)); // R7

    AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> (|status)); // R7

endmodule

// File: rtl/smi_guard_top.sv
module smi_guard_top
    import smi_guard_pkg::*;
#(
    parameter int TICK_PERIOD = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              smm_active,
    output logic              smi_n,
    output logic [REG_W-1:0]  smi_status,
    output logic              flash_wr_permit
);

    logic [REG_W-1:0]   en_q;
    logic               lock_q;
    logic               we_q;
    logic               bwp_q;
    logic               sw_evt;
    logic               flash_evt;
    logic [REG_W-1:0]   clr_mask;
    logic               tick;
    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] sts;

    smi_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .en_q      (en_q),
        .lock_q    (lock_q),
        .we_q      (we_q),
        .bwp_q     (bwp_q),
        .sw_evt    (sw_evt),
        .flash_evt (flash_evt),
        .clr_mask  (clr_mask)
    );

    smi_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    always_comb begin
        evt_vec            = '0;
        evt_vec[SRC_SW]    = sw_evt;
        evt_vec[SRC_TICK]  = tick;
        evt_vec[SRC_FLASH] = flash_evt;
    end

    smi_event_core #(.NSRC(NUM_SRC)) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .glb_en (en_q[BIT_GLOBAL]),
        .src_en (en_q[NUM_SRC:1]),
        .evt    (evt_vec),
        .clr    (clr_mask[NUM_SRC:1]),
        .status (sts),
        .smi_n  (smi_n)
    );

    assign smi_status      = REG_W'({sts, 1'b0});
    assign flash_wr_permit = we_q & (~bwp_q | smm_active);

    always_comb begin
        case (reg_addr)
            OFS_ENABLE:  reg_rdata = en_q;
            OFS_STATUS:  reg_rdata = smi_status;
            OFS_LOCK:    reg_rdata = {{(REG_W-1){1'b0}}, lock_q};
            OFS_BIOSCTL: reg_rdata = {{(REG_W-2){1'b0}}, bwp_q, we_q};
            default:     reg_rdata = '0;
        endcase
    end

    AST_BWP_BLOCKS_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (bwp_q && !smm_active) |-> !flash_wr_permit); // R9

    AST_PERMIT_NEEDS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        flash_wr_permit |-> we_q); // R9

endmodule

// File: tb/test_smi_guard_top.sv
module test_smi_guard_top;

    localparam int PER = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        smm_active = 1'b0;
    logic        smi_n;
    logic [31:0] smi_status;
    logic        flash_wr_permit;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int exp_q[$];
    int log_t[$];
    bit free_log = 1'b0;

    always #2 clk = ~clk;

    smi_guard_top #(.TICK_PERIOD(PER)) i_smi_guard_top (
        .clk             (clk),
        .rst_n           (rst_n),
        .reg_wr          (reg_wr),
        .reg_addr        (reg_addr),
        .reg_wdata       (reg_wdata),
        .reg_rdata       (reg_rdata),
        .smm_active      (smm_active),
        .smi_n           (smi_n),
        .smi_status      (smi_status),
        .flash_wr_permit (flash_wr_permit)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected pulse cycles and compares against observed ones
    always @(negedge clk) begin
        if (rst_n && smi_n === 1'b0) begin
            if (free_log) begin
                log_t.push_back(cyc);
            end else if (exp_q.size() == 0) begin
                check("R2/R3/R5 unexpected pulse cycle", cyc, 32'hFFFF_FFFF);
            end else begin
                int e;
                e = exp_q.pop_front();
                check("R3/R5 pulse cycle", cyc, e);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit expect_smi);
        @(negedge clk);
        if (expect_smi) exp_q.push_back(cyc + 1);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        check(tag, exp_q.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 smi_n", {31'b0, smi_n}, 32'h1);
        check("R1 status", smi_status, 32'h0);
        check("R1 permit", {31'b0, flash_wr_permit}, 32'h0);
        rd(8'h30, v); check("R1 R10 enable", v, 32'h0);
        rd(8'h40, v); check("R1 R10 lock", v, 32'h0);
        rd(8'hDC, v); check("R1 R10 bioscontrol", v, 32'h0);

        // R2 source enabled, global off: no pulse, status still set (R7)
        wr(8'h30, 32'h2, 0);
        wr(8'hB2, 32'h0, 0);
        drain("R2 no pulse");
        check("R7 status set while disabled", smi_status & 32'hA, 32'h2);
        rd(8'h34, v); check("R10 status read", v & 32'hA, 32'h2);
        wr(8'h34, 32'h2, 0);
        @(negedge clk);
        check("R7 write-1-clear", smi_status & 32'hA, 32'h0);

        // R3 software trigger
        wr(8'h30, 32'h3, 0);
        wr(8'hB2, 32'h0, 1);
        drain("R3 pulse seen");
        check("R3 status", smi_status & 32'hA, 32'h2);
        wr(8'hB2, 32'h0, 1);
        drain("R3 second pulse");
        wr(8'h34, 32'hE, 0);

        // R5 flash write-enable raises event
        wr(8'h30, 32'h9, 0);
        wr(8'hDC, 32'h1, 1);
        drain("R5 pulse seen");
        check("R5 status", smi_status & 32'hA, 32'h8);
        rd(8'hDC, v); check("R5 R10 we readback", v, 32'h1);
        check("R9 permit no bwp", {31'b0, flash_wr_permit}, 32'h1);
        wr(8'hDC, 32'h1, 0);
        drain("R5 rewrite no pulse");
        wr(8'hDC, 32'h0, 0);
        @(negedge clk);
        check("R9 permit after clear", {31'b0, flash_wr_permit}, 32'h0);
        wr(8'h34, 32'hE, 0);

        // R8 suppression
        wr(8'h30, 32'hFFFF_FFFE, 0);
        rd(8'h30, v); check("R8 R10 enable readback", v, 32'hFFFF_FFFE);
        wr(8'hDC, 32'h1, 0);
        drain("R8 no pulse");
        rd(8'hDC, v); check("R8 we stays", v, 32'h1);
        check("R8 permit high", {31'b0, flash_wr_permit}, 32'h1);
        check("R8 status flash", smi_status & 32'h8, 32'h8);

        // R9 SMM-only protection
        wr(8'hDC, 32'h3, 0);
        @(negedge clk);
        check("R9 bwp no smm", {31'b0, flash_wr_permit}, 32'h0);
        smm_active = 1'b1;
        #1;
        check("R9 bwp in smm", {31'b0, flash_wr_permit}, 32'h1);
        smm_active = 1'b0;
        wr(8'hDC, 32'h0, 0);
        wr(8'h34, 32'hE, 0);

        // R4 periodic source
        @(negedge clk);
        free_log = 1'b1;
        wr(8'h30, 32'h5, 0);
        repeat (4 * PER + 2) @(negedge clk);
        wr(8'h30, 32'h1, 0);
        @(negedge clk);
        @(negedge clk);
        free_log = 1'b0;
        check("R4 pulse count", (log_t.size() >= 3) ? 32'h1 : 32'h0, 32'h1);
        for (int i = 0; i + 1 < log_t.size(); i++) begin
            check("R4 pulse spacing", log_t[i+1] - log_t[i], PER);
        end
        wr(8'h34, 32'hE, 0);

        // R6 lock freezes global enable
        wr(8'h30, 32'h9, 0);
        wr(8'h40, 32'h1, 0);
        rd(8'h40, v); check("R6 lock set", v, 32'h1);
        wr(8'h30, 32'hA, 0);
        rd(8'h30, v); check("R6 bit0 frozen others written", v, 32'hB);
        wr(8'h40, 32'h0, 0);
        rd(8'h40, v); check("R6 lock sticky", v, 32'h1);
        wr(8'hDC, 32'h1, 1);
        drain("R6 flash pulse despite suppression try");
        wr(8'hB2, 32'h0, 1);
        drain("R6 trigger pulse under lock");

        check("final queue empty", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule